// File: doc/BRIEF.md
# USB Receive Packet Parser

This block sits behind the 8-bit receive side of a USB 2.0 transceiver macrocell on the device side. It watches the packet-in-progress and byte-valid strobes and groups the incoming bytes into packets. The first byte of each packet is the packet identifier, and the block checks it against its complement nibble. Token packets are decoded into identifier, device address and endpoint number. A token is passed on only when its 5-bit CRC is correct, its length is exact, no receive error was reported and the address belongs to this device. Data packets are forwarded as a byte stream with their two CRC bytes removed, a last flag on the final payload byte and an error flag on that same byte.

To know that a byte is payload and not the CRC trailer, the block holds three bytes internally. A payload byte leaves the block when the third byte after it arrives, or, for the final payload byte, one cycle after the packet ends. Handshake, special and start-of-frame packets are consumed without any output. Bit unstuffing, line decoding, handshake replies and endpoint bookkeeping belong to other blocks.

Top module: `usb_rx_parser`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `tok_vld`, `dat_vld`, `dat_last` and `dat_err` are low.
- R2: A packet whose first byte has bits [7:4] not equal to the bitwise inverse of bits [3:0] produces no token and no data output.
- R3: Token identifiers are those with identifier bits [1:0] = 01 (OUT 0001, IN 1001, SETUP 1101). After the packet ends, `tok_vld` pulses for one cycle with `tok_pid` = identifier nibble, `tok_addr` = byte 1 bits [6:0], and `tok_ep` = {byte 2 bits [2:0], byte 1 bit 7}. The pulse comes in the cycle after the first clock edge that sees `rx_active` low.
- R4: A token is accepted only when its address equals `dev_addr`. An unassigned device (`dev_addr` = 0) therefore accepts only address 0.
- R5: A token is dropped when the residual of the 5-bit CRC (x^5+x^2+1, seed all ones, bits sent LSB first, byte 2 bits [7:3] holding the inverted CRC MSB first) over bytes 1 and 2 is not 5'b01100. It is also dropped when the packet does not carry exactly two bytes after the identifier.
- R6: Start-of-frame (0101), handshake (bits [1:0] = 10) and special (bits [1:0] = 00) identifiers produce no output.
- R7: For a data identifier (bits [1:0] = 11), every byte except the final two is forwarded in order on `dat_byte` with `dat_vld`. `dat_pid` carries the identifier nibble. `dat_last` is high only on the final payload byte, which appears one cycle after the packet end is seen.
- R8: When the 16-bit CRC residual (x^16+x^15+x^2+1, seed all ones) over all bytes after the identifier is not 16'h800D, `dat_err` is high on the final payload byte.
- R9: A receive error reported while `rx_active` is high sets `dat_err` on the final payload byte of a data packet. For a token packet, it causes the token to be dropped.
- R10: A data packet with fewer than three bytes after the identifier produces no data output.
- R11: Cycles with `rx_valid` low inside a packet carry no byte and do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_active | input | 1 | Packet in progress |
| rx_valid | input | 1 | rx_data holds a byte this cycle |
| rx_data | input | 8 | Received byte |
| rx_error | input | 1 | Receive error from the transceiver |
| dev_addr | input | 7 | Address currently assigned to the device |
| tok_vld | output | 1 | Decoded token valid (one cycle) |
| tok_pid | output | 4 | Token identifier |
| tok_addr | output | 7 | Token device address |
| tok_ep | output | 4 | Token endpoint number |
| dat_vld | output | 1 | Payload byte valid |
| dat_byte | output | 8 | Payload byte |
| dat_last | output | 1 | Final payload byte of the packet |
| dat_err | output | 1 | Packet is corrupt (CRC or receive error) |
| dat_pid | output | 4 | Identifier of the data packet being forwarded |

## Verification
The bench aims at the trailer boundary. It uses one-byte payloads, where the single payload byte has to wait for the end of the packet. It also uses packets of exactly two bytes after the identifier, which must stay silent. A design that strips the wrong number of bytes would leak a CRC byte or lose the final payload byte, and a bad hold count would mark `dat_last` on the wrong byte. Tokens are sent with a flipped CRC bit, with an extra byte, with a receive error, with a foreign address and as a start-of-frame packet. Each of these would appear on `tok_vld` if the corresponding filter were missing. Packets are also sent with idle gaps in `rx_valid`, which a design that counts cycles instead of bytes would corrupt.

// File: rtl/usb_rx_parser.sv
module usb_rx_parser (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_active,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       rx_error,
  input  logic [6:0] dev_addr,
  output logic       tok_vld,
  output logic [3:0] tok_pid,
  output logic [6:0] tok_addr,
  output logic [3:0] tok_ep,
  output logic       dat_vld,
  output logic [7:0] dat_byte,
  output logic       dat_last,
  output logic       dat_err,
  output logic [3:0] dat_pid
);

  localparam logic [4:0]  RES5  = 5'b01100;
  localparam logic [15:0] RES16 = 16'h800D;

  function automatic logic [4:0] nxt5(input logic [4:0] c, input logic [7:0] d);
    logic [4:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = {r[3:0], 1'b0} ^ ((d[i] ^ r[4]) ? 5'h05 : 5'h00);
    return r;
  endfunction

  function automatic logic [15:0] nxt16(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = {r[14:0], 1'b0} ^ ((d[i] ^ r[15]) ? 16'h8005 : 16'h0000);
    return r;
  endfunction

  logic        busy, got_pid, err_q;
  logic [7:0]  pid_q, h0, h1, h2;
  logic [1:0]  cnt;
  logic [4:0]  c5;
  logic [15:0] c16;

  wire pid_ok  = (pid_q[7:4] == ~pid_q[3:0]);
  wire is_tok  = (pid_q[1:0] == 2'b01) && (pid_q[3:0] != 4'b0101);
  wire is_dat  = (pid_q[1:0] == 2'b11);
  wire byte_in = rx_active & rx_valid;
  wire pkt_end = busy & ~rx_active;
  wire fwd     = byte_in & got_pid & pid_ok & is_dat & (cnt == 2'd3);
  wire tok_ok  = got_pid & pid_ok & is_tok & (cnt == 2'd2) & ~err_q &
                 (c5 == RES5) & (h1[6:0] == dev_addr);
  wire dat_end = got_pid & pid_ok & is_dat & (cnt == 2'd3);

  assign dat_pid = pid_q[3:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; got_pid <= 1'b0; err_q <= 1'b0; cnt <= 2'd0;
      c5 <= 5'h1F; c16 <= 16'hFFFF;
      pid_q <= 8'h00; h0 <= 8'h00; h1 <= 8'h00; h2 <= 8'h00;
      tok_vld <= 1'b0; tok_pid <= 4'h0; tok_addr <= 7'h00; tok_ep <= 4'h0;
      dat_vld <= 1'b0; dat_byte <= 8'h00; dat_last <= 1'b0; dat_err <= 1'b0;
    end else begin
      tok_vld  <= 1'b0;
      dat_vld  <= 1'b0;
      dat_last <= 1'b0;
      dat_err  <= 1'b0;
      if (rx_active) begin
        busy <= 1'b1;
        if (rx_error) err_q <= 1'b1;
        if (rx_valid) begin
          if (!got_pid) begin
            got_pid <= 1'b1;
            pid_q   <= rx_data;
          end else begin
            if (cnt != 2'd3) cnt <= cnt + 2'd1;
            c5  <= nxt5(c5, rx_data);
            c16 <= nxt16(c16, rx_data);
            h0  <= rx_data;
            h1  <= h0;
            h2  <= h1;
          end
        end
        if (fwd) begin
          dat_vld  <= 1'b1;
          dat_byte <= h2;
        end
      end else if (pkt_end) begin
        busy <= 1'b0; got_pid <= 1'b0; err_q <= 1'b0; cnt <= 2'd0;
        c5 <= 5'h1F; c16 <= 16'hFFFF;
        if (tok_ok) begin
          tok_vld  <= 1'b1;
          tok_pid  <= pid_q[3:0];
          tok_addr <= h1[6:0];
          tok_ep   <= {h0[2:0], h1[7]};
        end
        if (dat_end) begin
          dat_vld  <= 1'b1;
          dat_byte <= h2;
          dat_last <= 1'b1;
          dat_err  <= err_q | (c16 != RES16);
        end
      end
    end
  end

endmodule

// File: rtl/usb_rx_parser_chk.sv
module usb_rx_parser_chk (
  input logic       clk,
  input logic       rst,
  input logic       rx_active,
  input logic       rx_valid,
  input logic [6:0] dev_addr,
  input logic       tok_vld,
  input logic [3:0] tok_pid,
  input logic [6:0] tok_addr,
  input logic       dat_vld,
  input logic       dat_last,
  input logic       dat_err
);

  AST_TOK_PULSE: assert property (@(posedge clk) disable iff (rst)
    tok_vld |=> !tok_vld); // R3

  AST_TOK_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    tok_vld |-> $past(!rx_active)); // R3

  AST_TOK_ADDR_MATCH: assert property (@(posedge clk) disable iff (rst)
    tok_vld |-> tok_addr == $past(dev_addr)); // R4

  AST_TOK_KIND: assert property (@(posedge clk) disable iff (rst)
    tok_vld |-> (tok_pid[1:0] == 2'b01) && (tok_pid != 4'b0101)); // R6

  AST_NO_TOK_AND_DATA: assert property (@(posedge clk) disable iff (rst)
    !(tok_vld && dat_vld)); // R6

  AST_MID_BYTE_ON_INPUT: assert property (@(posedge clk) disable iff (rst)
    (dat_vld && !dat_last) |-> $past(rx_active && rx_valid)); // R11

  AST_LAST_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    dat_last |-> $past(!rx_active) && dat_vld); // R7

  AST_ERR_ON_LAST: assert property (@(posedge clk) disable iff (rst)
    dat_err |-> dat_last); // R8

endmodule

bind usb_rx_parser usb_rx_parser_chk u_chk (.*);

// File: tb/tb_usb_rx_parser.sv
module tb_usb_rx_parser;
  localparam int PERIOD = 10;

  logic clk = 0, rst = 1;
  logic rx_active = 0, rx_valid = 0, rx_error = 0;
  logic [7:0] rx_data = 0;
  logic [6:0] dev_addr = 0;
  logic tok_vld, dat_vld, dat_last, dat_err;
  logic [3:0] tok_pid, tok_ep, dat_pid;
  logic [6:0] tok_addr;
  logic [7:0] dat_byte;

  always #(PERIOD/2) clk = ~clk;

  usb_rx_parser dut (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] pk [0:70];
  int pn;
  logic [7:0] cb [0:70];
  bit cl [0:70];
  bit ce [0:70];
  int ncap = 0, ntok = 0;
  logic [3:0] last_tpid, last_dpid;
  logic [6:0] last_taddr;
  logic [3:0] last_tep;

  always @(negedge clk) begin
    if (dat_vld && ncap < 71) begin
      cb[ncap] = dat_byte; cl[ncap] = dat_last; ce[ncap] = dat_err;
      last_dpid = dat_pid; ncap++;
    end
    if (tok_vld) begin
      ntok++; last_tpid = tok_pid; last_taddr = tok_addr; last_tep = tok_ep;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic build_tok(input logic [3:0] pid, input logic [6:0] a,
                           input logic [3:0] ep, input bit flip);
    logic [4:0] c; logic [10:0] bits; logic [4:0] f;
    c = 5'h1F; bits = {ep, a};
    for (int i = 0; i < 11; i++)
      c = {c[3:0], 1'b0} ^ ((bits[i] ^ c[4]) ? 5'h05 : 5'h00);
    for (int j = 0; j < 5; j++) f[j] = ~c[4-j];
    if (flip) f[2] = ~f[2];
    pk[0] = {~pid, pid}; pk[1] = {ep[0], a}; pk[2] = {f, ep[3:1]}; pn = 3;
  endtask

  task automatic build_dat(input logic [3:0] pid, input int n,
                           input logic [7:0] seed, input bit bad);
    logic [15:0] c; logic [7:0] b;
    c = 16'hFFFF;
    pk[0] = {~pid, pid};
    for (int k = 0; k < n; k++) begin
      b = seed + 8'(k * 7);
      pk[k+1] = b;
      for (int i = 0; i < 8; i++)
        c = {c[14:0], 1'b0} ^ ((b[i] ^ c[15]) ? 16'h8005 : 16'h0000);
    end
    for (int i = 0; i < 8; i++) begin
      pk[n+1][i] = ~c[15-i];
      pk[n+2][i] = ~c[7-i];
    end
    if (bad) pk[n+2][0] = ~pk[n+2][0];
    pn = n + 3;
  endtask

  task automatic send(input int err_at, input bit gaps);
    ncap = 0; ntok = 0;
    @(negedge clk); rx_active = 1;
    @(negedge clk);
    for (int k = 0; k < pn; k++) begin
      rx_valid = 1; rx_data = pk[k]; rx_error = (k == err_at);
      @(negedge clk);
      if (gaps) begin rx_valid = 0; rx_error = 0; @(negedge clk); end
    end
    rx_valid = 0; rx_error = 0; rx_active = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_payload(input string req, input int n,
                                input logic [7:0] seed, input bit err);
    check(ncap == n, req, "payload count", ncap, n);
    for (int k = 0; k < n && k < ncap; k++) begin
      check(cb[k] == seed + 8'(k * 7), req, "payload byte", cb[k], seed + 8'(k * 7));
      check(cl[k] == (k == n - 1), req, "last flag", cl[k], k == n - 1);
      check(ce[k] == (err && k == n - 1), req, "error flag", ce[k], err && k == n - 1);
    end
  endtask

  task automatic t_reset;
    check(!tok_vld && !dat_vld && !dat_last && !dat_err, "R1", "outputs in reset",
          {tok_vld, dat_vld, dat_last, dat_err}, 0);
    @(negedge clk); rst = 0;
    @(negedge clk);
    check(!tok_vld && !dat_vld, "R1", "outputs after reset", {tok_vld, dat_vld}, 0);
  endtask

  task automatic t_token;
    dev_addr = 7'd5;
    build_tok(4'b0001, 7'd5, 4'd11, 0); send(-1, 0);
    check(ntok == 1, "R3", "token count", ntok, 1);
    check(last_tpid == 4'b0001, "R3", "token pid", last_tpid, 1);
    check(last_taddr == 7'd5, "R3", "token addr", last_taddr, 5);
    check(last_tep == 4'd11, "R3", "token ep", last_tep, 11);
    check(ncap == 0, "R3", "no data from token", ncap, 0);
    build_tok(4'b1001, 7'd5, 4'd6, 0); send(-1, 1);
    check(ntok == 1 && last_tep == 4'd6, "R11", "token with gaps ep", last_tep, 6);
  endtask

  task automatic t_addr;
    dev_addr = 7'd5;
    build_tok(4'b0001, 7'd9, 4'd1, 0); send(-1, 0);
    check(ntok == 0, "R4", "foreign address dropped", ntok, 0);
    dev_addr = 7'd0;
    build_tok(4'b1101, 7'd0, 4'd0, 0); send(-1, 0);
    check(ntok == 1 && last_tpid == 4'b1101, "R4", "address 0 accepted", ntok, 1);
    build_tok(4'b1101, 7'd5, 4'd0, 0); send(-1, 0);
    check(ntok == 0, "R4", "unassigned rejects addr 5", ntok, 0);
  endtask

  task automatic t_tok_bad;
    dev_addr = 7'd33;
    build_tok(4'b1001, 7'd33, 4'd2, 1); send(-1, 0);
    check(ntok == 0, "R5", "bad crc5 dropped", ntok, 0);
    build_tok(4'b1001, 7'd33, 4'd2, 0); pk[3] = 8'h00; pn = 4; send(-1, 0);
    check(ntok == 0, "R5", "long token dropped", ntok, 0);
    build_tok(4'b1001, 7'd33, 4'd2, 0); send(1, 0);
    check(ntok == 0, "R9", "token with rx error dropped", ntok, 0);
  endtask

  task automatic t_pid;
    dev_addr = 7'd5;
    build_tok(4'b0001, 7'd5, 4'd1, 0); pk[0] = 8'hF1; send(-1, 0);
    check(ntok == 0, "R2", "bad complement token", ntok, 0);
    build_dat(4'b0011, 6, 8'h40, 0); pk[0] = 8'h33; send(-1, 0);
    check(ncap == 0, "R2", "bad complement data", ncap, 0);
  endtask

  task automatic t_other;
    dev_addr = 7'd5;
    build_tok(4'b0101, 7'd5, 4'd0, 0); send(-1, 0);
    check(ntok == 0 && ncap == 0, "R6", "start-of-frame silent", ntok + ncap, 0);
    pk[0] = 8'hD2; pn = 1; send(-1, 0);
    check(ntok == 0 && ncap == 0, "R6", "handshake silent", ntok + ncap, 0);
    build_dat(4'b1100, 4, 8'h10, 0); send(-1, 0);
    check(ntok == 0 && ncap == 0, "R6", "special silent", ntok + ncap, 0);
  endtask

  task automatic t_data;
    build_dat(4'b0011, 5, 8'h21, 0); send(-1, 0);
    expect_payload("R7", 5, 8'h21, 0);
    check(last_dpid == 4'b0011, "R7", "data pid", last_dpid, 3);
    build_dat(4'b1011, 1, 8'h9C, 0); send(-1, 0);
    expect_payload("R7", 1, 8'h9C, 0);
    build_dat(4'b1011, 12, 8'h05, 0); send(-1, 1);
    expect_payload("R11", 12, 8'h05, 0);
  endtask

  task automatic t_data_err;
    build_dat(4'b0011, 4, 8'h70, 1); send(-1, 0);
    expect_payload("R8", 4, 8'h70, 1);
    build_dat(4'b1011, 4, 8'h11, 0); send(3, 0);
    expect_payload("R9", 4, 8'h11, 1);
  endtask

  task automatic t_short;
    build_dat(4'b0011, 0, 8'h00, 0); send(-1, 0);
    check(ncap == 0, "R10", "zero payload silent", ncap, 0);
    pk[0] = 8'h4B; pk[1] = 8'h12; pn = 2; send(-1, 0);
    check(ncap == 0, "R10", "one byte after pid silent", ncap, 0);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_token;
    t_addr;
    t_tok_bad;
    t_pid;
    t_other;
    t_data;
    t_data_err;
    t_short;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule